// File: doc/BRIEF.md
# Receive FIFO with Idle Timeout

A byte-wide first-in first-out buffer placed between a serial receiver and a processor read port. The receiver pushes each completed byte with a one-cycle strobe. The reader sees the oldest byte on a show-ahead data output and removes it with a read strobe. The block keeps a count of held bytes, a sticky overrun flag and two interrupt causes: a fill-level cause and a receive-idle cause. The fill-level cause fires when the count reaches a programmed threshold. The receive-idle cause fires when bytes wait unread and no new byte has arrived for longer than a set number of bit times.

A bit-tick input, one cycle wide per serial bit time, stands in for the baud generator and drives the idle timer. A FIFO enable gates all traffic. A clear command empties the buffer and leaves every setting as it was. The settings are the threshold, the idle-detect enable and the interrupt enable.

Top module: `rx_idle_fifo`

## Requirements
- R1: After reset the count is 0, the FIFO is empty, and overrun, level-hit, idle and interrupt are all low.
- R2: While enabled, a write strobe on a non-full FIFO stores the byte. `rd_data_o` always shows the oldest held byte. A read strobe on a non-empty FIFO removes that byte. The count equals bytes stored minus bytes removed and never exceeds DEPTH. A write and a read in the same cycle keep the count.
- R3: A write strobe while the count equals DEPTH drops the byte and sets `overrun_o`. This holds even if a read occurs in the same cycle. `overrun_o` stays set until a clear.
- R4: While `en_i` is low, write and read strobes have no effect: the count, the head byte and overrun are unchanged.
- R5: A clear pulse empties the FIFO and resets overrun and the idle timer in the following cycle. It takes priority over a write or read in the same cycle and does not alter the threshold or the enables.
- R6: `level_hit_o` is high exactly when the threshold is non-zero and the count is at or above it. A threshold of 0 never sets it.
- R7: With idle detection enabled and enabled traffic, the idle timer counts bit ticks while the FIFO holds data. `idle_o` goes high once more than IDLE_BITS ticks (default 8) have been counted since the last write, read or start of holding data. The timer restarts on every accepted write or read. It is held at 0 while the FIFO is empty, while the FIFO is disabled and while idle detection is off.
- R8: `irq_o` is high when `rx_irq_en_i` is high and either `level_hit_o` or `idle_o` is high; it is low whenever `rx_irq_en_i` is low.
- R9: A read strobe on an empty FIFO is ignored: the count stays 0 and a later write followed by a read returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | FIFO operation enable |
| clear_i | input | 1 | Clear command pulse |
| idle_det_en_i | input | 1 | Receive-idle detection enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| thresh_i | input | $clog2(DEPTH+1) | Fill-level threshold, 0 disables |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| wr_valid_i | input | 1 | Byte write strobe from the receiver |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Read strobe from the processor port |
| rd_data_o | output | 8 | Oldest held byte |
| rd_valid_o | output | 1 | FIFO holds at least one byte |
| count_o | output | $clog2(DEPTH+1) | Number of held bytes |
| full_o | output | 1 | Count equals DEPTH |
| overrun_o | output | 1 | Sticky dropped-byte flag |
| level_hit_o | output | 1 | Count at or above a non-zero threshold |
| idle_o | output | 1 | Receive-idle condition |
| irq_o | output | 1 | Receive interrupt |

## Verification
The idle timer boundary gets the closest look. After exactly IDLE_BITS ticks the flag must stay low and the next tick must raise it. An off-by-one counter would flag a tick early or late. A timer that ignored reads, or kept counting on an empty FIFO, would flag idle with nothing to read. Overflow with a concurrent read is driven on purpose, since a design that let a pop make room in the same cycle would store the byte instead of flagging overrun. A clear paired with a write is also driven: a design giving the write priority would come out of the clear holding one byte. Long stretches of randomized traffic cover wrap-around of the pointers. During those stretches the enable, the threshold and the two interrupt enables are flipped.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] rx_byte_t;
  typedef struct packed {
    logic clr;
    logic push;
    logic pop;
  } fifo_op_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fifo_op_t op_i,
  input  rx_byte_t wr_data_i,
  output rx_byte_t rd_data_o,
  output logic [CW-1:0] count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_byte_t mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (op_i.push) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (op_i.clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (op_i.push) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (op_i.pop)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      unique case ({op_i.push, op_i.pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data_o = mem[rd_ptr_q];
  assign count_o   = count_q;
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
  parameter int unsigned IDLE_BITS = 8,
  localparam int unsigned TW = $clog2(IDLE_BITS + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic idle_o
);
  localparam logic [TW-1:0] LIMIT = TW'(IDLE_BITS);

  logic [TW-1:0] cnt_q;

  // saturates one past LIMIT so the flag holds until restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q <= LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign idle_o = cnt_q > LIMIT;
endmodule

// File: rtl/rxf_level_cmp.sv
module rxf_level_cmp #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] thresh_i,
  output logic          hit_o
);
  always_comb begin
    hit_o = (thresh_i != '0) && (count_i >= thresh_i);
  end
endmodule

// File: rtl/rx_idle_fifo.sv
module rx_idle_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDLE_BITS = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clear_i,
  input  logic          idle_det_en_i,
  input  logic          rx_irq_en_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          bit_tick_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_req_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          overrun_o,
  output logic          level_hit_o,
  output logic          idle_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  fifo_op_t      op;
  logic [CW-1:0] count;
  logic          empty, full, active, ovf_set, restart;
  logic          overrun_q, idle, level_hit;
  rx_byte_t      head;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign active = en_i && !clear_i;

  always_comb begin
    op.clr  = clear_i;
    op.push = active && wr_valid_i && !full;
    op.pop  = active && rd_req_i && !empty;
  end

  assign ovf_set = active && wr_valid_i && full;
  assign restart = clear_i || !en_i || !idle_det_en_i || empty || op.push || op.pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       overrun_q <= 1'b0;
    else if (clear_i)  overrun_q <= 1'b0;
    else if (ovf_set)  overrun_q <= 1'b1;
  end

  rxf_store #(.DEPTH(DEPTH)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .wr_data_i (rx_byte_t'(wr_data_i)),
    .rd_data_o (head),
    .count_o   (count)
  );

  rxf_idle_timer #(.IDLE_BITS(IDLE_BITS)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (bit_tick_i),
    .idle_o    (idle)
  );

  rxf_level_cmp #(.CW(CW)) level_i (
    .count_i  (count),
    .thresh_i (thresh_i),
    .hit_o    (level_hit)
  );

  assign rd_data_o   = head;
  assign rd_valid_o  = !empty;
  assign count_o     = count;
  assign full_o      = full;
  assign overrun_o   = overrun_q;
  assign level_hit_o = level_hit;
  assign idle_o      = idle;
  assign irq_o       = rx_irq_en_i && (level_hit || idle);
endmodule

// File: rtl/rx_idle_fifo_chk.sv
module rx_idle_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDLE_BITS = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          clear_i,
  input logic          rx_irq_en_i,
  input logic [CW-1:0] thresh_i,
  input logic          wr_valid_i,
  input logic          rd_req_i,
  input logic          rd_valid_o,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          overrun_o,
  input logic          level_hit_o,
  input logic          idle_o,
  input logic          irq_o
);
  localparam logic [CW-1:0] MAXC = CW'(DEPTH);

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= MAXC);

  assert_push_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && wr_valid_i && !full_o && !rd_req_i) |=> count_o == $past(count_o) + 1'b1);

  assert_overrun_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && wr_valid_i && full_o) |=> overrun_o);

  assert_overrun_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clear_i) |=> overrun_o);

  assert_disabled_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(count_o));

  assert_clear_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0) && !overrun_o);

  assert_level_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i == '0) |-> !level_hit_o);

  assert_idle_has_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> rd_valid_o);

  assert_idle_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && ((wr_valid_i && !full_o) || (rd_req_i && rd_valid_o))) |=> !idle_o);

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_irq_en_i |-> !irq_o);
endmodule

bind rx_idle_fifo rx_idle_fifo_chk #(.DEPTH(DEPTH), .IDLE_BITS(IDLE_BITS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .clear_i     (clear_i),
  .rx_irq_en_i (rx_irq_en_i),
  .thresh_i    (thresh_i),
  .wr_valid_i  (wr_valid_i),
  .rd_req_i    (rd_req_i),
  .rd_valid_o  (rd_valid_o),
  .count_o     (count_o),
  .full_o      (full_o),
  .overrun_o   (overrun_o),
  .level_hit_o (level_hit_o),
  .idle_o      (idle_o),
  .irq_o       (irq_o)
);

// File: tb/rx_idle_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_idle_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int IDLE_BITS = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 0, clear_i = 0, idle_det_en_i = 0, rx_irq_en_i = 0;
  logic [CW-1:0] thresh_i = '0;
  logic bit_tick_i = 0, wr_valid_i = 0, rd_req_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic rd_valid_o, full_o, overrun_o, level_hit_o, idle_o, irq_o;
  logic [CW-1:0] count_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  rx_idle_fifo #(.DEPTH(DEPTH), .IDLE_BITS(IDLE_BITS)) dut_i (.*);

  // reference model
  logic [7:0] mq[$];
  bit movr;
  int midle;

  always @(posedge clk_i or negedge rst_ni) begin
    int sz;
    bit pu, po;
    if (!rst_ni) begin
      mq.delete(); movr = 0; midle = 0;
    end else begin
      sz = mq.size();
      if (clear_i) begin
        mq.delete(); movr = 0; midle = 0;
      end else if (en_i) begin
        po = rd_req_i && sz > 0;
        pu = wr_valid_i && sz < DEPTH;
        if (wr_valid_i && sz == DEPTH) movr = 1;
        if (po) void'(mq.pop_front());
        if (pu) mq.push_back(wr_data_i);
        if (!idle_det_en_i || sz == 0 || pu || po) midle = 0;
        else if (bit_tick_i && midle <= IDLE_BITS) midle++;
      end else begin
        midle = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_level();
    return (thresh_i != 0) && (mq.size() >= thresh_i);
  endfunction

  function automatic bit m_idle();
    return midle > IDLE_BITS;
  endfunction

  task automatic compare();
    bit lv, id;
    lv = m_level();
    id = m_idle();
    chk(count_o == mq.size(), "R2 count", count_o, mq.size());
    if (mq.size() > 0) chk(rd_data_o == mq[0], "R2 head", rd_data_o, mq[0]);
    chk(rd_valid_o == (mq.size() > 0), "R2 valid", rd_valid_o, mq.size() > 0);
    chk(full_o == (mq.size() == DEPTH), "R3 full", full_o, mq.size() == DEPTH);
    chk(overrun_o == movr, "R3 overrun", overrun_o, movr);
    chk(level_hit_o == lv, "R6 level", level_hit_o, lv);
    chk(idle_o == id, "R7 idle", idle_o, id);
    chk(irq_o == (rx_irq_en_i && (lv || id)), "R8 irq", irq_o, rx_irq_en_i && (lv || id));
  endtask

  // one clock; compare at the following falling edge, before new inputs
  task automatic cyc();
    @(negedge clk_i);
    if (rst_ni) compare();
  endtask

  task automatic idle_in();
    wr_valid_i = 0; rd_req_i = 0; clear_i = 0; bit_tick_i = 0;
  endtask

  task automatic push(input logic [7:0] d);
    wr_valid_i = 1; wr_data_i = d; cyc(); wr_valid_i = 0;
  endtask

  task automatic pop();
    rd_req_i = 1; cyc(); rd_req_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick_i = 1; cyc(); bit_tick_i = 0; cyc();
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    int c0;
    // R1 reset state
    #12;
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(!rd_valid_o && !overrun_o && !level_hit_o && !idle_o && !irq_o, "R1 flags",
        {rd_valid_o, overrun_o, level_hit_o, idle_o, irq_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    cyc();

    // R2 basic order
    en_i = 1;
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    pop(); pop();
    wr_valid_i = 1; rd_req_i = 1; wr_data_i = 8'hA5; cyc(); idle_in();
    chk(count_o == 3, "R2 concurrent", count_o, 3);

    // R9 read on empty
    pop(); pop(); pop();
    pop();
    chk(count_o == 0, "R9 empty read count", count_o, 0);
    push(8'h3C);
    chk(rd_data_o == 8'h3C, "R9 head after empty read", rd_data_o, 8'h3C);
    pop();

    // R3 fill and overrun with concurrent read
    for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i));
    chk(full_o == 1, "R3 full", full_o, 1);
    wr_valid_i = 1; rd_req_i = 1; wr_data_i = 8'hEE; cyc(); idle_in();
    chk(overrun_o == 1, "R3 overrun set", overrun_o, 1);
    chk(count_o == DEPTH - 1, "R3 byte dropped", count_o, DEPTH - 1);
    push(8'h55);
    chk(overrun_o == 1, "R3 sticky", overrun_o, 1);

    // R4 disabled ignores traffic
    keep = rd_data_o; c0 = count_o;
    en_i = 0;
    for (int i = 0; i < 3; i++) begin
      wr_valid_i = 1; rd_req_i = 1; wr_data_i = 8'h01; cyc();
    end
    idle_in();
    chk(count_o == c0, "R4 count held", count_o, c0);
    chk(rd_data_o == keep, "R4 head held", rd_data_o, keep);
    en_i = 1;

    // R5 clear beats write
    thresh_i = CW'(1);
    clear_i = 1; wr_valid_i = 1; wr_data_i = 8'h77; cyc(); idle_in();
    chk(count_o == 0, "R5 cleared", count_o, 0);
    chk(overrun_o == 0, "R5 overrun cleared", overrun_o, 0);
    push(8'h42);
    chk(level_hit_o == 1, "R5 threshold kept", level_hit_o, 1);
    pop();

    // R6 threshold crossing
    thresh_i = CW'(3); rx_irq_en_i = 1;
    push(8'h01); push(8'h02);
    chk(level_hit_o == 0, "R6 below", level_hit_o, 0);
    push(8'h03);
    chk(irq_o == 1, "R6 R8 at threshold", irq_o, 1);
    thresh_i = '0; cyc();
    chk(level_hit_o == 0, "R6 zero threshold", level_hit_o, 0);
    pop(); pop(); pop();

    // R7 idle boundary
    idle_det_en_i = 1;
    push(8'h9A);
    ticks(IDLE_BITS);
    chk(idle_o == 0, "R7 at limit", idle_o, 0);
    ticks(1);
    chk(idle_o == 1, "R7 past limit", idle_o, 1);
    chk(irq_o == 1, "R8 idle irq", irq_o, 1);
    rx_irq_en_i = 0; cyc();
    chk(irq_o == 0, "R8 gated", irq_o, 0);
    rx_irq_en_i = 1;
    push(8'h9B);
    chk(idle_o == 0, "R7 restart on write", idle_o, 0);
    ticks(IDLE_BITS + 3);
    pop();
    chk(idle_o == 0, "R7 restart on read", idle_o, 0);
    ticks(IDLE_BITS + 2);
    chk(idle_o == 1, "R7 idle again", idle_o, 1);
    pop();
    ticks(IDLE_BITS + 2);
    chk(idle_o == 0, "R7 empty holds timer", idle_o, 0);

    // randomized traffic, model compared every clock
    for (int seg = 0; seg < 12; seg++) begin
      int wp, rp, tp;
      wp = (seg % 3 == 0) ? 5 : 40;
      rp = (seg % 4 == 1) ? 5 : 35;
      tp = 30;
      thresh_i = CW'($urandom_range(0, DEPTH));
      idle_det_en_i = $urandom_range(0, 3) != 0;
      rx_irq_en_i = $urandom_range(0, 1);
      for (int i = 0; i < 300; i++) begin
        en_i = $urandom_range(0, 19) != 0;
        clear_i = $urandom_range(0, 149) == 0;
        wr_valid_i = $urandom_range(0, 99) < wp;
        rd_req_i = $urandom_range(0, 99) < rp;
        bit_tick_i = $urandom_range(0, 99) < tp;
        wr_data_i = 8'($urandom);
        cyc();
      end
      idle_in();
    end
    cyc();

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule